// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides when a processor core leaves its normal flow for an exception, and it computes every register update that the switch requires. Seven request lines come in: a reset request, an undefined-instruction trap, a software trap, an instruction-fetch abort, a data-access abort, a normal interrupt and a fast interrupt. The block also reads the live status word, the current program counter and a configuration bit that moves the vector table high. It arbitrates among the requests by a fixed priority and applies the interrupt mask bits that the status word carries. On the next clock edge it issues the new status word, the saved copy of the old status word, the return address for the target mode's link register and the vector address for the program counter.

It also performs the exception return. On request, it gives back the saved status word and the link value of the current mode as the new status word and program counter. The register bank and the instruction pipeline sit outside the block. They supply the saved status and link values of the current mode, and they apply the write enables that the block drives.

Status word layout: mode in bits [4:0], instruction-set state bit at 5, fast-interrupt mask at 6, interrupt mask at 7. Mode codes are User 5'h10, Fast 5'h11, Irq 5'h12, Supervisor 5'h13, Abort 5'h17, Undef 5'h1B and System 5'h1F.

Top module: `exc_seq`

## Requirements
- R1: When an exception is taken, `spsr_we` pulses, `spsr_data` equals the status word sampled on the request cycle, and `spsr_mode`, `lr_mode` and `status_out[4:0]` all carry the target mode. `status_we`, `lr_we` and `pc_we` pulse together with `spsr_we`.
- R2: Target modes: reset request and software trap enter Supervisor (5'h13), the undefined trap enters Undef (5'h1B), both aborts enter Abort (5'h17), the normal interrupt enters Irq (5'h12) and the fast interrupt enters Fast (5'h11).
- R3: The vector offset from the table base is 0x00 for reset, 0x04 for undefined, 0x08 for the software trap, 0x0C for the fetch abort, 0x10 for the data abort, 0x18 for the normal interrupt and 0x1C for the fast interrupt. Offset 0x14 is never produced.
- R4: With `high_vec` at 0 the table base is 0x00000000. With `high_vec` at 1 it is 0xFFFF0000.
- R5: When several requests are active together, the one taken is decided in this order, highest first: reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined, software trap.
- R6: On entry the new status word keeps bits [31:8] of the old one, sets bit 7, clears bit 5, and sets bit 6 for reset and fast interrupt only. Bit 6 is otherwise kept from the old word.
- R7: A normal interrupt request is ignored while status bit 7 is 1. A fast interrupt request is ignored while status bit 6 is 1. A lower-priority request that is not masked is then taken instead.
- R8: On entry `lr_data` equals `cur_pc` plus 4.
- R9: A return request in Fast, Irq, Supervisor, Abort or Undef mode drives `status_out` to `saved_status_in` and `pc_out` to `link_in`, with `status_we` and `pc_we` pulsing and with `spsr_we` and `lr_we` low.
- R10: A return request in User, System or any other mode code is ignored and produces no write and no `done`. An exception request in the same cycle wins over a return.
- R11: Outputs update on the clock edge that samples the request. `done` is a one-cycle pulse. Requests that are present in the cycle where `done` is high are not acted on, so a request that is held high is taken on every second cycle.
- R12: While `rst_n` is low, all write enables and `done` are 0 and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction trap request |
| req_swi | input | 1 | Software trap request |
| req_pabt | input | 1 | Instruction-fetch abort request |
| req_dabt | input | 1 | Data-access abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| high_vec | input | 1 | Selects the high vector table base |
| ret_req | input | 1 | Exception return request |
| cur_status | input | 32 | Live status word |
| cur_pc | input | 32 | Current program counter |
| saved_status_in | input | 32 | Saved status word of the current mode |
| link_in | input | 32 | Link register of the current mode |
| status_we | output | 1 | Write enable for the live status word |
| status_out | output | 32 | New live status word |
| spsr_we | output | 1 | Write enable for a saved status word |
| spsr_mode | output | 5 | Mode whose saved status word is written |
| spsr_data | output | 32 | Saved status value |
| lr_we | output | 1 | Write enable for a link register |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | 32 | Return address |
| pc_we | output | 1 | Program counter write enable |
| pc_out | output | 32 | New program counter |
| done | output | 1 | One-cycle pulse marking a completed entry or return |

## Verification
The bench drives every source alone and in overlapping sets, so an arbiter with two neighbours swapped produces the wrong vector and the wrong mode. It sets each mask bit with the matching interrupt both alone and alongside a lower source. A design that ignored a mask would take the masked interrupt, and one that masked too broadly would drop the lower source. Return is tried in a privileged mode, in User and in System mode, and together with an interrupt. Returning from an unprivileged mode, or letting the return beat the exception, shows up as a stray write. A request held high checks that `done` falls between two entries instead of staying high.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int MODE_W = 5;
  localparam int NSRC   = 7;
  localparam int I_BIT  = 7;
  localparam int F_BIT  = 6;
  localparam int T_BIT  = 5;
  localparam int OFS_W  = 5;

  // source index doubles as priority rank: 0 is highest
  localparam int S_RESET = 0;
  localparam int S_DABT  = 1;
  localparam int S_FIQ   = 2;
  localparam int S_IRQ   = 3;
  localparam int S_PABT  = 4;
  localparam int S_UNDEF = 5;
  localparam int S_SWI   = 6;

  localparam logic [MODE_W-1:0] M_USR = 5'h10;
  localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] M_SVC = 5'h13;
  localparam logic [MODE_W-1:0] M_ABT = 5'h17;
  localparam logic [MODE_W-1:0] M_UND = 5'h1B;
  localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

  function automatic logic [OFS_W-1:0] vec_offset(input int src);
    case (src)
      S_RESET: return 5'h00;
      S_UNDEF: return 5'h04;
      S_SWI:   return 5'h08;
      S_PABT:  return 5'h0C;
      S_DABT:  return 5'h10;
      S_IRQ:   return 5'h18;
      default: return 5'h1C;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] target_mode(input int src);
    case (src)
      S_RESET, S_SWI: return M_SVC;
      S_UNDEF:        return M_UND;
      S_PABT, S_DABT: return M_ABT;
      S_IRQ:          return M_IRQ;
      default:        return M_FIQ;
    endcase
  endfunction

  function automatic logic sets_fmask(input int src);
    return (src == S_RESET) || (src == S_FIQ);
  endfunction

  function automatic logic [XLEN-1:0] entry_status(input logic [XLEN-1:0] cur, input int src);
    logic [XLEN-1:0] s;
    s = cur;
    s[I_BIT] = 1'b1;
    s[F_BIT] = cur[F_BIT] | sets_fmask(src);
    s[T_BIT] = 1'b0;
    s[MODE_W-1:0] = target_mode(src);
    return s;
  endfunction

  function automatic logic has_saved_copy(input logic [MODE_W-1:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) || (m == M_ABT) || (m == M_UND);
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req,
  input  logic         irq_masked,
  input  logic         fiq_masked,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N-1:0] qual;

  always_comb begin
    qual = req;
    qual[S_IRQ] = req[S_IRQ] & ~irq_masked;
    qual[S_FIQ] = req[S_FIQ] & ~fiq_masked;
  end

  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (qual[i] && !found) begin
        grant[i] = 1'b1;
        found = 1'b1;
      end
    end
  end

  assign any = |qual;
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int              N       = NSRC,
  parameter int              W       = XLEN,
  parameter logic [W-1:0]    LO_BASE = 32'h0000_0000,
  parameter logic [W-1:0]    HI_BASE = 32'hFFFF_0000,
  parameter logic [W-1:0]    RET_ADJ = 32'd4
) (
  input  logic [N-1:0]      grant,
  input  logic [W-1:0]      cur_status,
  input  logic [W-1:0]      cur_pc,
  input  logic              high_vec,
  output logic [W-1:0]      new_status,
  output logic [W-1:0]      new_pc,
  output logic [W-1:0]      link_addr,
  output logic [MODE_W-1:0] tgt_mode
);
  logic [W-1:0]      st_part  [N];
  logic [OFS_W-1:0]  ofs_part [N];
  logic [MODE_W-1:0] md_part  [N];

  // one slice per source, gated by its grant bit
  for (genvar g = 0; g < N; g++) begin : g_src
    assign st_part[g]  = grant[g] ? entry_status(cur_status, g) : '0;
    assign ofs_part[g] = grant[g] ? vec_offset(g)               : '0;
    assign md_part[g]  = grant[g] ? target_mode(g)              : '0;
  end

  always_comb begin
    logic [OFS_W-1:0] ofs;
    new_status = '0;
    ofs        = '0;
    tgt_mode   = '0;
    for (int i = 0; i < N; i++) begin
      new_status = new_status | st_part[i];
      ofs        = ofs | ofs_part[i];
      tgt_mode   = tgt_mode | md_part[i];
    end
    new_pc    = (high_vec ? HI_BASE : LO_BASE) | W'(ofs);
    link_addr = cur_pc + RET_ADJ;
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int           W       = XLEN,
  parameter logic [W-1:0] LO_BASE = 32'h0000_0000,
  parameter logic [W-1:0] HI_BASE = 32'hFFFF_0000,
  parameter logic [W-1:0] RET_ADJ = 32'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic              high_vec,
  input  logic              ret_req,
  input  logic [W-1:0]      cur_status,
  input  logic [W-1:0]      cur_pc,
  input  logic [W-1:0]      saved_status_in,
  input  logic [W-1:0]      link_in,
  output logic              status_we,
  output logic [W-1:0]      status_out,
  output logic              spsr_we,
  output logic [MODE_W-1:0] spsr_mode,
  output logic [W-1:0]      spsr_data,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [W-1:0]      lr_data,
  output logic              pc_we,
  output logic [W-1:0]      pc_out,
  output logic              done
);
  logic [NSRC-1:0]   req_vec;
  logic [NSRC-1:0]   grant;
  logic              take;
  logic              ret_ok;
  logic              accept;
  logic [W-1:0]      ent_status;
  logic [W-1:0]      ent_pc;
  logic [W-1:0]      ent_link;
  logic [MODE_W-1:0] ent_mode;
  logic              any_req;

  always_comb begin
    req_vec          = '0;
    req_vec[S_RESET] = req_reset;
    req_vec[S_DABT]  = req_dabt;
    req_vec[S_FIQ]   = req_fiq;
    req_vec[S_IRQ]   = req_irq;
    req_vec[S_PABT]  = req_pabt;
    req_vec[S_UNDEF] = req_undef;
    req_vec[S_SWI]   = req_swi;
  end

  exc_arbiter #(.N(NSRC)) u_arb (
    .req        (req_vec),
    .irq_masked (cur_status[I_BIT]),
    .fiq_masked (cur_status[F_BIT]),
    .grant      (grant),
    .any        (take)
  );

  exc_entry_calc #(
    .N(NSRC), .W(W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .RET_ADJ(RET_ADJ)
  ) u_calc (
    .grant      (grant),
    .cur_status (cur_status),
    .cur_pc     (cur_pc),
    .high_vec   (high_vec),
    .new_status (ent_status),
    .new_pc     (ent_pc),
    .link_addr  (ent_link),
    .tgt_mode   (ent_mode)
  );

  assign any_req = |req_vec;
  assign accept  = ~done;
  assign ret_ok  = ret_req & has_saved_copy(cur_status[MODE_W-1:0]) & ~take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_we  <= 1'b0;
      status_out <= '0;
      spsr_we    <= 1'b0;
      spsr_mode  <= '0;
      spsr_data  <= '0;
      lr_we      <= 1'b0;
      lr_mode    <= '0;
      lr_data    <= '0;
      pc_we      <= 1'b0;
      pc_out     <= '0;
      done       <= 1'b0;
    end else begin
      status_we <= 1'b0;
      spsr_we   <= 1'b0;
      lr_we     <= 1'b0;
      pc_we     <= 1'b0;
      done      <= 1'b0;
      if (accept && take) begin
        status_we  <= 1'b1;
        status_out <= ent_status;
        spsr_we    <= 1'b1;
        spsr_mode  <= ent_mode;
        spsr_data  <= cur_status;
        lr_we      <= 1'b1;
        lr_mode    <= ent_mode;
        lr_data    <= ent_link;
        pc_we      <= 1'b1;
        pc_out     <= ent_pc;
        done       <= 1'b1;
      end else if (accept && ret_ok) begin
        status_we  <= 1'b1;
        status_out <= saved_status_in;
        pc_we      <= 1'b1;
        pc_out     <= link_in;
        done       <= 1'b1;
      end
    end
  end

  // R11: completion never lasts more than one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: an entry writes all four targets coherently
  assert_entry_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (status_we && lr_we && pc_we && spsr_mode == lr_mode
                 && status_out[MODE_W-1:0] == spsr_mode));

  // R6: every entry leaves the interrupt mask set and the state bit clear
  assert_imask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (status_out[I_BIT] && !status_out[T_BIT]));

  // R7: a masked normal interrupt alone produces nothing
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_irq && cur_status[I_BIT] && !ret_req &&
     !req_reset && !req_dabt && !req_fiq && !req_pabt && !req_undef && !req_swi)
    |=> !done);

  // R5: at most one source granted at a time
  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10: return from an unprivileged or banked-less mode does nothing
  assert_ret_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ret_req && !any_req &&
     (cur_status[MODE_W-1:0] == M_USR || cur_status[MODE_W-1:0] == M_SYS))
    |=> !done);

  // R3: vector addresses are word aligned and skip the unused slot
  assert_vec_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (pc_out[1:0] == 2'b00 && pc_out[4:0] != 5'h14));

  // R9: a return touches neither saved status nor link
  assert_ret_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_we && !spsr_we) |-> (!lr_we && pc_we));
endmodule

// File: tb/sim_exc_seq.sv
module sim_exc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
  logic        req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic        high_vec = 0, ret_req = 0;
  logic [31:0] cur_status = '0, cur_pc = '0, saved_status_in = '0, link_in = '0;
  logic        status_we, spsr_we, lr_we, pc_we, done;
  logic [31:0] status_out, spsr_data, lr_data, pc_out;
  logic [4:0]  spsr_mode, lr_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  exc_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .high_vec(high_vec), .ret_req(ret_req),
    .cur_status(cur_status), .cur_pc(cur_pc),
    .saved_status_in(saved_status_in), .link_in(link_in),
    .status_we(status_we), .status_out(status_out),
    .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_data(spsr_data),
    .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
    .pc_we(pc_we), .pc_out(pc_out), .done(done)
  );

  localparam logic [23:0] UPPER = 24'hA5C3E1;

  // req order: reset undef swi pabt dabt irq fiq
  // fields: req[54:48] hv[47] stat[46:39] take[38] mode[37:33] vec[32:1] f[0]
  localparam int NV = 18;
  localparam logic [54:0] TBL [NV] = '{
    {7'b1000000, 1'b0, 8'h10, 1'b1, 5'h13, 32'h0000_0000, 1'b1},
    {7'b0100000, 1'b0, 8'h10, 1'b1, 5'h1B, 32'h0000_0004, 1'b0},
    {7'b0010000, 1'b1, 8'h10, 1'b1, 5'h13, 32'hFFFF_0008, 1'b0},
    {7'b0001000, 1'b0, 8'h30, 1'b1, 5'h17, 32'h0000_000C, 1'b0},
    {7'b0000100, 1'b1, 8'h10, 1'b1, 5'h17, 32'hFFFF_0010, 1'b0},
    {7'b0000010, 1'b0, 8'h10, 1'b1, 5'h12, 32'h0000_0018, 1'b0},
    {7'b0000001, 1'b0, 8'h10, 1'b1, 5'h11, 32'h0000_001C, 1'b1},
    {7'b0000010, 1'b0, 8'h90, 1'b0, 5'h00, 32'h0000_0000, 1'b0},
    {7'b0000001, 1'b0, 8'h50, 1'b0, 5'h00, 32'h0000_0000, 1'b0},
    {7'b1111111, 1'b1, 8'h10, 1'b1, 5'h13, 32'hFFFF_0000, 1'b1},
    {7'b0000111, 1'b0, 8'h10, 1'b1, 5'h17, 32'h0000_0010, 1'b0},
    {7'b0001011, 1'b0, 8'h10, 1'b1, 5'h11, 32'h0000_001C, 1'b1},
    {7'b0101010, 1'b0, 8'h10, 1'b1, 5'h12, 32'h0000_0018, 1'b0},
    {7'b0111000, 1'b0, 8'h10, 1'b1, 5'h17, 32'h0000_000C, 1'b0},
    {7'b0110000, 1'b0, 8'h10, 1'b1, 5'h1B, 32'h0000_0004, 1'b0},
    {7'b0000011, 1'b0, 8'h50, 1'b1, 5'h12, 32'h0000_0018, 1'b1},
    {7'b0001010, 1'b0, 8'h90, 1'b1, 5'h17, 32'h0000_000C, 1'b0},
    {7'b0010011, 1'b1, 8'hD0, 1'b1, 5'h13, 32'hFFFF_0008, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_reqs(input logic [6:0] r);
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = r;
  endtask

  task automatic idle_cycle();
    set_reqs(7'b0);
    ret_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 done", {31'b0, done}, 32'd0);
    chk("R12 enables", {28'b0, status_we, spsr_we, lr_we, pc_we}, 32'd0);
    chk("R12 pc_out", pc_out, 32'd0);
    chk("R12 status_out", status_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1..R8
    for (int i = 0; i < NV; i++) begin
      logic [54:0] e;
      logic [31:0] st, pc, exp_st;
      e  = TBL[i];
      st = {UPPER, e[46:39]};
      pc = 32'h0000_1000 + 32'(i) * 32'h10;
      set_reqs(e[54:48]);
      high_vec   = e[47];
      cur_status = st;
      cur_pc     = pc;
      @(negedge clk);
      if (e[38]) begin
        exp_st = {UPPER, 1'b1, e[0], 1'b0, e[37:33]};
        chk($sformatf("R11 done v%0d", i), {31'b0, done}, 32'd1);
        chk($sformatf("R3 R4 R5 vector v%0d", i), pc_out, e[32:1]);
        chk($sformatf("R2 R6 status v%0d", i), status_out, exp_st);
        chk($sformatf("R1 saved v%0d", i), spsr_data, st);
        chk($sformatf("R1 spsr_mode v%0d", i), {27'b0, spsr_mode}, {27'b0, e[37:33]});
        chk($sformatf("R8 link v%0d", i), lr_data, pc + 32'd4);
        chk($sformatf("R8 lr_mode v%0d", i), {27'b0, lr_mode}, {27'b0, e[37:33]});
        chk($sformatf("R1 enables v%0d", i), {28'b0, status_we, spsr_we, lr_we, pc_we}, 32'hF);
      end else begin
        chk($sformatf("R7 masked done v%0d", i), {31'b0, done}, 32'd0);
        chk($sformatf("R7 masked enables v%0d", i),
            {28'b0, status_we, spsr_we, lr_we, pc_we}, 32'd0);
      end
      idle_cycle();
    end

    // R9: return from Irq mode
    cur_status      = {UPPER, 8'h92};
    saved_status_in = 32'h6000_0010;
    link_in         = 32'h0000_2468;
    ret_req         = 1'b1;
    @(negedge clk);
    chk("R9 status", status_out, 32'h6000_0010);
    chk("R9 pc", pc_out, 32'h0000_2468);
    chk("R9 enables", {28'b0, status_we, spsr_we, lr_we, pc_we}, 32'h9);
    chk("R9 done", {31'b0, done}, 32'd1);
    idle_cycle();

    // R10: return ignored in User and System
    cur_status = {UPPER, 8'h10};
    ret_req    = 1'b1;
    @(negedge clk);
    chk("R10 user done", {31'b0, done}, 32'd0);
    chk("R10 user enables", {28'b0, status_we, spsr_we, lr_we, pc_we}, 32'd0);
    chk("R10 user pc unchanged", pc_out, 32'h0000_2468);
    cur_status = {UPPER, 8'h1F};
    @(negedge clk);
    chk("R10 system done", {31'b0, done}, 32'd0);
    chk("R10 system status unchanged", status_out, 32'h6000_0010);
    idle_cycle();

    // R10: exception beats return
    cur_status = {UPPER, 8'h12};
    cur_pc     = 32'h0000_4000;
    high_vec   = 1'b0;
    ret_req    = 1'b1;
    req_irq    = 1'b1;
    @(negedge clk);
    chk("R10 exc wins pc", pc_out, 32'h0000_0018);
    chk("R10 exc wins spsr_we", {31'b0, spsr_we}, 32'd1);
    chk("R10 exc wins link", lr_data, 32'h0000_4004);
    idle_cycle();

    // R11: held request taken every second cycle
    cur_status = {UPPER, 8'h10};
    req_fiq    = 1'b1;
    @(negedge clk);
    chk("R11 held c1", {31'b0, done}, 32'd1);
    @(negedge clk);
    chk("R11 held c2", {31'b0, done}, 32'd0);
    chk("R11 held c2 enables", {28'b0, status_we, spsr_we, lr_we, pc_we}, 32'd0);
    @(negedge clk);
    chk("R11 held c3", {31'b0, done}, 32'd1);
    idle_cycle();
    chk("R11 released", {31'b0, done}, 32'd0);

    // R12: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 rerun pc", pc_out, 32'd0);
    chk("R12 rerun enables", {27'b0, done, status_we, spsr_we, lr_we, pc_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    report();
    $finish;
  end
endmodule